// File: doc/BRIEF.md
# Windowed On-Time Overpower Monitor

This block guards a protective clamp against being kept on too long. A one-bit clamp-active input is brought into the clock domain through two flip-flops. Its level is then sampled on each time-base tick, and every sampled-high tick is added to an accumulator. Time is cut into back-to-back observation windows of a fixed number of ticks. At the default parameters this is one million ticks of one microsecond, so each window lasts one second. If a window closes without a fault, the accumulator is cleared and the next window starts from zero.

A selection input picks one of two on-time limits. At the defaults these are 51,200 ticks (51.2 ms) and 76,800 ticks (76.8 ms). On the first tick where the running total goes past the selected limit, the block latches a fault and asserts a shutdown request. It does not wait for the window to close. After that, both counters freeze and the clamp input has no further effect. Only the power-on reset releases the fault. The accumulator and the window position are brought out for observation.

Top module: `onmon_top`

## Requirements
- R1: A tick occurs every TICK_DIV clock cycles (every cycle when TICK_DIV is 1). The window position `dbg_win` counts ticks from 0 to WINDOW_TICKS-1 and then wraps to 0, so a window lasts exactly WINDOW_TICKS ticks.
- R2: The accumulator `dbg_acc` grows by one on each tick where the synchronised clamp level is high. The clamp input reaches the counter two clock cycles after it is sampled, so a clamp pulse held for N cycles (with TICK_DIV 1) adds exactly N.
- R3: With `limit_sel` = 0 the limit is LIMIT_LO. With `limit_sel` = 1 the limit is LIMIT_HI.
- R4: The fault sets on the first tick where the accumulated count goes above the selected limit. A total equal to the limit does not set it, and the block does not wait for the window to end.
- R5: When a window closes without a fault, `dbg_acc` becomes 0 at the closing tick. The sample taken on that closing tick still belongs to the closing window, so on-time split across two windows is never summed together.
- R6: `shutdown` asserts in the same cycle as `fault`.
- R7: Once set, `fault` and `shutdown` stay high until `rst_n` is driven low. While the fault is held, `dbg_acc` and `dbg_win` stay fixed and the clamp input is ignored. During reset all outputs read 0.
- R8: When the limit is crossed on the same tick that closes a window, the fault wins. It latches, `dbg_acc` keeps the crossing count instead of clearing, and `dbg_win` shows 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-on reset, asynchronous assertion |
| clamp_on | input | 1 | Clamp-active level, asynchronous to clk |
| limit_sel | input | 1 | Selects the on-time limit: 0 low, 1 high |
| fault | output | 1 | Latched overpower fault |
| shutdown | output | 1 | Shutdown request, follows the latched fault |
| dbg_acc | output | ACC_W | Current accumulated on-time in ticks |
| dbg_win | output | WIN_W | Current tick position inside the window |

## Verification
Two functions can meet on one tick: the window closing, which clears the accumulator, and the limit crossing, which latches the fault. To make them meet, the bench lines up a clamp pulse on the window position so that the count passing the limit lands exactly on the closing tick. It then expects the fault to be set, the count to be kept, and the window position to read 0. A second run uses the same alignment but a pulse one tick shorter. It shows the total reaching only the limit and the accumulator clearing, which confirms that the two events were actually coincident in the first run.

// File: rtl/onmon_pkg.sv
package onmon_pkg;

  // Saturating increment: never rolls past the top value of the counter.
  function automatic int unsigned sat_inc(input int unsigned val, input int unsigned top);
    return (val >= top) ? top : val + 1;
  endfunction

  // Limit chosen by the variant select.
  function automatic int unsigned pick_limit(input logic sel, input int unsigned lo,
                                             input int unsigned hi);
    return sel ? hi : lo;
  endfunction

  // Width needed to hold values 0..n.
  function automatic int unsigned width_for(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/onmon_sync.sv
module onmon_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= 1'b0;
      q_o  <= 1'b0;
    end else begin
      meta <= d_i;
      q_o  <= meta;
    end
  end
endmodule

// File: rtl/onmon_tick.sv
module onmon_tick #(
  parameter int unsigned TICK_DIV = 250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic halt_i,
  output logic tick_o
);
  generate
    if (TICK_DIV <= 1) begin : g_every_cycle
      assign tick_o = ~halt_i;
    end else begin : g_divider
      localparam int unsigned DW = $clog2(TICK_DIV);
      logic [DW-1:0] div_q;
      assign tick_o = ~halt_i && (div_q == DW'(TICK_DIV - 1));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      div_q <= '0;
        else if (!halt_i) div_q <= tick_o ? '0 : div_q + 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/onmon_window.sv
module onmon_window #(
  parameter int unsigned WINDOW_TICKS = 1_000_000,
  localparam int unsigned WIN_W = onmon_pkg::width_for(WINDOW_TICKS - 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             halt_i,
  output logic [WIN_W-1:0] pos_o,
  output logic             end_o
);
  logic step;
  assign step  = tick_i && !halt_i;
  assign end_o = step && (pos_o == WIN_W'(WINDOW_TICKS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pos_o <= '0;
    else if (step) pos_o <= end_o ? '0 : pos_o + 1'b1;
  end

  // The window position restarts at zero right after a closing tick.
  assert_window_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    end_o |=> (pos_o == '0));

  // Without a tick or while halted the position does not move.
  assert_window_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(pos_o));
endmodule

// File: rtl/onmon_accum.sv
module onmon_accum #(
  parameter int unsigned ACC_W = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             halt_i,
  input  logic             level_i,
  input  logic             win_end_i,
  input  logic [ACC_W-1:0] limit_i,
  output logic [ACC_W-1:0] acc_o,
  output logic             trip_o
);
  import onmon_pkg::*;

  localparam int unsigned ACC_TOP = (2 ** ACC_W) - 1;

  logic             step;
  logic [ACC_W-1:0] next_acc;

  assign step     = tick_i && !halt_i;
  assign next_acc = level_i ? ACC_W'(sat_inc(int'(acc_o), ACC_TOP)) : acc_o;
  assign trip_o   = step && (next_acc > limit_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      acc_o <= '0;
    else if (step)
      acc_o <= (win_end_i && !trip_o) ? '0 : next_acc;
  end

  // Per tick the total grows by at most one unless a window clears it.
  assert_acc_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !win_end_i) |=> (acc_o >= $past(acc_o)) && (acc_o - $past(acc_o) <= 1));

  // A window closing without a fault empties the accumulator.
  assert_acc_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (win_end_i && step && !trip_o) |=> (acc_o == '0));

  // A crossing on the closing tick keeps its count.
  assert_collision_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (win_end_i && trip_o) |=> (acc_o != '0));

  // The total never wraps back to a smaller value without a window close.
  assert_no_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!win_end_i) |=> (acc_o >= $past(acc_o)));
endmodule

// File: rtl/onmon_top.sv
module onmon_top #(
  parameter int unsigned TICK_DIV     = 250,
  parameter int unsigned WINDOW_TICKS = 1_000_000,
  parameter int unsigned LIMIT_LO     = 51_200,
  parameter int unsigned LIMIT_HI     = 76_800,
  localparam int unsigned LIMIT_MAX   = (LIMIT_HI > LIMIT_LO) ? LIMIT_HI : LIMIT_LO,
  localparam int unsigned ACC_W       = onmon_pkg::width_for(LIMIT_MAX + 1),
  localparam int unsigned WIN_W       = onmon_pkg::width_for(WINDOW_TICKS - 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clamp_on,
  input  logic             limit_sel,
  output logic             fault,
  output logic             shutdown,
  output logic [ACC_W-1:0] dbg_acc,
  output logic [WIN_W-1:0] dbg_win
);
  import onmon_pkg::*;

  // Named internal events.
  logic             clamp_s;
  logic             tick;
  logic             win_end;
  logic             trip;
  logic             halt;
  logic [ACC_W-1:0] limit_now;

  assign halt      = fault;
  assign limit_now = ACC_W'(pick_limit(limit_sel, LIMIT_LO, LIMIT_HI));

  onmon_sync u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (clamp_on),
    .q_o   (clamp_s)
  );

  onmon_tick #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk    (clk),
    .rst_n  (rst_n),
    .halt_i (halt),
    .tick_o (tick)
  );

  onmon_window #(.WINDOW_TICKS(WINDOW_TICKS)) u_win (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_i (tick),
    .halt_i (halt),
    .pos_o  (dbg_win),
    .end_o  (win_end)
  );

  onmon_accum #(.ACC_W(ACC_W)) u_acc (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (tick),
    .halt_i    (halt),
    .level_i   (clamp_s),
    .win_end_i (win_end),
    .limit_i   (limit_now),
    .acc_o     (dbg_acc),
    .trip_o    (trip)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault    <= 1'b0;
      shutdown <= 1'b0;
    end else if (trip) begin
      fault    <= 1'b1;
      shutdown <= 1'b1;
    end
  end

  // A crossing latches the fault on the next edge.
  assert_trip_latch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    trip |=> fault);

  // Shutdown tracks the fault.
  assert_shutdown_pair_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault) |-> shutdown);

  // The fault is sticky.
  assert_fault_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> (fault && shutdown));

  // Under a held fault nothing moves.
  assert_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> ($stable(dbg_acc) && $stable(dbg_win)));
endmodule

// File: tb/sim_onmon_top.sv
`timescale 1ns/1ps
module sim_onmon_top;
  localparam int unsigned WIN  = 200;
  localparam int unsigned LO   = 20;
  localparam int unsigned HI   = 30;
  localparam int unsigned AW   = $clog2(HI + 2);
  localparam int unsigned WW   = $clog2(WIN);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          clamp_on = 1'b0;
  logic          limit_sel = 1'b0;
  logic          fault, shutdown;
  logic [AW-1:0] dbg_acc;
  logic [WW-1:0] dbg_win;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  onmon_top #(.TICK_DIV(1), .WINDOW_TICKS(WIN), .LIMIT_LO(LO), .LIMIT_HI(HI)) u0 (
    .clk(clk), .rst_n(rst_n), .clamp_on(clamp_on), .limit_sel(limit_sel),
    .fault(fault), .shutdown(shutdown), .dbg_acc(dbg_acc), .dbg_win(dbg_win)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    clamp_on = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wait_win(input int v);
    do @(negedge clk); while (dbg_win != WW'(v));
  endtask

  // High for n cycles, then three cycles so the last sample is counted.
  task automatic pulse(input int n);
    clamp_on = 1'b1;
    repeat (n) @(negedge clk);
    clamp_on = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset_state();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R7 fault in reset", fault, 0);
    chk("R7 shutdown in reset", shutdown, 0);
    chk("R7 acc in reset", dbg_acc, 0);
    chk("R1 window in reset", dbg_win, 0);
    rst_n = 1'b1;
  endtask

  task automatic t_below_limit();
    int len;
    limit_sel = 1'b0;
    wait_win(5);
    pulse(1);
    chk("R2 single-cycle pulse", dbg_acc, 1);
    pulse(LO - 1);
    chk("R4 total at limit", dbg_acc, LO);
    chk("R4 no fault at limit", fault, 0);
    wait_win(0);
    chk("R5 cleared at window end", dbg_acc, 0);
    chk("R5 no fault after window", fault, 0);
    len = 0;
    do begin @(negedge clk); len++; end while (dbg_win != 0);
    chk("R1 window length", len, WIN);
  endtask

  task automatic t_above_limit();
    int w;
    do_reset();
    limit_sel = 1'b0;
    wait_win(5);
    pulse(LO + 1);
    chk("R4 fault above limit", fault, 1);
    chk("R6 shutdown with fault", shutdown, 1);
    chk("R4 acc at crossing", dbg_acc, LO + 1);
    chk("R4 fault before window end", (dbg_win != 0) ? 1 : 0, 1);
    w = dbg_win;
    pulse(40);
    chk("R7 clamp ignored", dbg_acc, LO + 1);
    chk("R7 window frozen", dbg_win, w);
    repeat (300) @(negedge clk);
    chk("R7 fault persists", fault, 1);
    chk("R7 shutdown persists", shutdown, 1);
    do_reset();
    @(negedge clk);
    chk("R7 reset clears fault", fault, 0);
    chk("R7 reset clears shutdown", shutdown, 0);
  endtask

  task automatic t_select_high();
    do_reset();
    limit_sel = 1'b1;
    wait_win(5);
    pulse(HI);
    chk("R3 high limit no fault", fault, 0);
    chk("R3 high limit count", dbg_acc, HI);
    pulse(1);
    chk("R3 high limit fault", fault, 1);
    limit_sel = 1'b0;
    do_reset();
  endtask

  task automatic t_split();
    do_reset();
    limit_sel = 1'b0;
    wait_win(180);
    pulse(30);
    chk("R5 split no fault", fault, 0);
    chk("R5 split new window count", dbg_acc, 12);
  endtask

  task automatic t_collision();
    do_reset();
    limit_sel = 1'b0;
    wait_win(177);
    pulse(LO);
    chk("R8 near miss no fault", fault, 0);
    chk("R8 near miss cleared", dbg_acc, 0);
    do_reset();
    wait_win(177);
    pulse(LO + 1);
    chk("R8 collision fault", fault, 1);
    chk("R8 collision keeps count", dbg_acc, LO + 1);
    chk("R8 collision window pos", dbg_win, 0);
  endtask

  initial begin
    t_reset_state();
    t_below_limit();
    t_above_limit();
    t_select_high();
    t_split();
    t_collision();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R1 watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule